// File: doc/BRIEF.md
# Stacked-Band Five-Level PWM Modulator

This block drives one leg of a five-level diode-clamped converter. It builds four sawtooth carriers and stacks them into contiguous voltage bands. Each carrier's height comes from its own amplitude input, which an outer balancing loop sets. The bottom edge of each band is recomputed from those heights, so the stack never has a gap or an overlap. A signed control reference is compared with every carrier in each switching period. The result drives four complementary gate pairs and a code that gives the output level. Three-phase operation uses three copies of the block fed with the same period tick and amplitudes.

Carrier 1 is the top band and spans `amp2` to `amp1+amp2`. Carrier 2 spans `0` to `amp2`. Carrier 3 spans `-amp3` to `0`. Carrier 4 spans `-(amp3+amp4)` to `-amp3`. Each carrier restarts at its band's bottom edge on the period tick. It then rises by `amp*ph/2^PH_W`, where `ph` counts clocks since the tick and stops at its maximum. Every gate pair has a programmable blanking interval: both switches stay off for that interval before either one turns on.

Top module: `stacked_band_pwm`

## Requirements
- R1: The band bottom edges are `amp2` for carrier 1, `0` for carrier 2, `-amp3` for carrier 3 and `-(amp3+amp4)` for carrier 4, using the latched amplitudes.
- R2: On a cycle with `period_tick` high, the ramp phase returns to 0. In every other cycle each carrier stays the same or rises, so it restarts from its bottom edge once per period.
- R3: Pair j (index j-1 on the gate vectors) follows only carrier j. It is commanded high-side when the signed reference is strictly greater than carrier j, and low-side otherwise.
- R4: `level` equals the number of pairs commanded high-side (0 to 4). The commanded pattern is always a thermometer filled from pair 4 upward.
- R5: With the reference inside one band, every pair below that band stays high-side and every pair above it stays low-side for the whole period. Only the pair of that band toggles.
- R6: Each amplitude input is clamped to at most 8192, one quarter of the positive reference range, when it is latched. A zero amplitude makes its carrier flat, so its pair does not toggle.
- R7: A pair is commanded high-side at the start of a period. Once it is commanded low-side, it stays low-side until the next tick, even if the reference rises again.
- R8: Amplitudes are latched only on a `period_tick` cycle. A change in the middle of a period takes effect only from the next period.
- R9: Each time a pair's commanded side changes, both of its gates are held off for `dead_len` cycles before the new gate turns on. With `dead_len` = 0 the switch-over is immediate.
- R10: While `rst_n` is low at a clock edge, the block resets: every `gate_lo` bit is 1, every `gate_hi` bit is 0 and `level` is 0.
- R11: The two gates of a pair are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse that starts a switching period |
| ref_in | input | 16 | Control reference, two's complement |
| amp1 | input | 16 | Height of the top band (unsigned) |
| amp2 | input | 16 | Height of the band just above zero (unsigned) |
| amp3 | input | 16 | Height of the band just below zero (unsigned) |
| amp4 | input | 16 | Height of the bottom band (unsigned) |
| dead_len | input | 4 | Blanking length in clock cycles |
| gate_hi | output | 4 | Upper switches; bit 0 is pair 1 (top band) |
| gate_lo | output | 4 | Complementary lower switches; bit 0 is pair 1 |
| level | output | 3 | Number of pairs commanded high-side |

## Verification
Several properties are checked on every cycle: the pair exclusion, both gates off during blanking, the thermometer shape of the commanded pattern against `level`, the amplitude ceiling, amplitudes holding between ticks, carriers rising within a period, and the reset state. Other behaviour can only be shown by the bench scenarios. These include the duty in each band, flat zero-height bands, the effect of the clamp on duty, the one turn-off per period under a toggling reference, and a mid-period amplitude change that takes effect only from the next period. The band placement itself is also shown only by those scenarios.

// File: rtl/stacked_pwm_pkg.sv
// Shared widths and types for the stacked-band modulator.
// Assumes a 16-bit reference; carriers carry two guard bits.
package stacked_pwm_pkg;
    localparam int NBANDS = 4;
    localparam int DATA_W = 16;
    localparam int CAR_W  = DATA_W + 2;
    localparam int LVL_W  = $clog2(NBANDS + 1);

    typedef logic        [DATA_W-1:0] amp_t;
    typedef logic signed [CAR_W-1:0]  carrier_t;
endpackage

// File: rtl/band_geometry.sv
// Latches clamped band heights on the period tick, runs the ramp phase
// counter and produces four stacked, contiguous carrier values.
// Assumes the tick spacing is about 2^PH_W clocks; the phase saturates.
module band_geometry
    import stacked_pwm_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  amp_t     amp_in [NBANDS],
    output carrier_t carrier [NBANDS]
);
    localparam amp_t AMP_MAX = amp_t'(1) << (DATA_W - 3);
    localparam int   PROD_W  = DATA_W + PH_W;

    amp_t            amp_q [NBANDS];
    logic [PH_W-1:0] ph_q;
    carrier_t        base  [NBANDS];

    // Ramp phase: restart on tick, count up, hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                ph_q <= '0;
        else if (tick)             ph_q <= '0;
        else if (ph_q != '1)       ph_q <= ph_q + 1'b1;
    end

    // Band edges from the latched heights, stacked around zero.
    always_comb begin
        base[0] = signed'({2'b00, amp_q[1]});
        base[1] = '0;
        base[2] = -signed'({2'b00, amp_q[2]});
        base[3] = -(signed'({2'b00, amp_q[2]}) + signed'({2'b00, amp_q[3]}));
    end

    for (genvar k = 0; k < NBANDS; k++) begin : g_band
        logic [PROD_W-1:0] prod;
        amp_t              rise;

        // Height latch: clamp and capture only on the period tick.
        always_ff @(posedge clk) begin
            if (!rst_n)     amp_q[k] <= '0;
            else if (tick)  amp_q[k] <= (amp_in[k] > AMP_MAX) ? AMP_MAX : amp_in[k];
        end

        // Ramp value: fraction ph/2^PH_W of the band height above its edge.
        always_comb begin
            prod       = {{PH_W{1'b0}}, amp_q[k]} * {{DATA_W{1'b0}}, ph_q};
            rise       = amp_t'(prod >> PH_W);
            carrier[k] = base[k] + signed'({2'b00, rise});
        end

        AST_AMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            amp_q[k] <= AMP_MAX) else $error("height above ceiling"); // R6
        AST_AMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(amp_q[k])) else $error("height moved mid-period"); // R8
        AST_RAMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> carrier[k] >= $past(carrier[k])) else $error("carrier fell"); // R2
    end
endmodule

// File: rtl/band_slicer.sv
// Compares the reference with one carrier and holds a set/reset latch:
// armed on the tick, disarmed at the first crossing, so one turn-off per period.
module band_slicer
    import stacked_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  carrier_t ref_ext,
    input  carrier_t carrier,
    output logic     demand
);
    logic armed_q;

    assign demand = armed_q && (ref_ext > carrier);

    // Latch: set at the period start, cleared once the ramp reaches the reference.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b0;
        else if (tick) armed_q <= 1'b1;
        else           armed_q <= demand;
    end
endmodule

// File: rtl/gate_deadtime.sv
// Turns one pair's demand into complementary gates with a blanking gap.
// A change of side restarts the gap; both gates are off while it runs.
module gate_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            demand,
    input  logic [DT_W-1:0] dead_len,
    output logic            side,
    output logic            up,
    output logic            lo
);
    logic [DT_W-1:0] cnt_q;

    // Commanded side and blanking counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side  <= 1'b0;
            cnt_q <= '0;
        end else if (demand != side) begin
            side  <= demand;
            cnt_q <= dead_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign up = side  && (cnt_q == '0);
    assign lo = !side && (cnt_q == '0);

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && lo)) else $error("shoot-through"); // R11
    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (!up && !lo)) else $error("gate on during blanking"); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (lo && !up)) else $error("reset state wrong"); // R10
endmodule

// File: rtl/stacked_band_pwm.sv
// Five-level stacked-band PWM for one converter leg: carrier geometry,
// four slicers and four dead-time stages; level counts high-side pairs.
// Assumes ticks arrive about every 2^PH_W clocks.
module stacked_band_pwm
    import stacked_pwm_pkg::*;
#(
    parameter int PH_W = 6,
    parameter int DT_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     period_tick,
    input  logic signed [DATA_W-1:0] ref_in,
    input  logic        [DATA_W-1:0] amp1,
    input  logic        [DATA_W-1:0] amp2,
    input  logic        [DATA_W-1:0] amp3,
    input  logic        [DATA_W-1:0] amp4,
    input  logic        [DT_W-1:0]   dead_len,
    output logic        [NBANDS-1:0] gate_hi,
    output logic        [NBANDS-1:0] gate_lo,
    output logic        [LVL_W-1:0]  level
);
    amp_t              amp_in  [NBANDS];
    carrier_t          carrier [NBANDS];
    carrier_t          ref_ext;
    logic [NBANDS-1:0] demand;
    logic [NBANDS-1:0] side;

    assign amp_in[0] = amp1;
    assign amp_in[1] = amp2;
    assign amp_in[2] = amp3;
    assign amp_in[3] = amp4;
    assign ref_ext   = {{(CAR_W-DATA_W){ref_in[DATA_W-1]}}, ref_in};

    band_geometry #(.PH_W(PH_W)) u_geom (
        .clk(clk), .rst_n(rst_n), .tick(period_tick),
        .amp_in(amp_in), .carrier(carrier)
    );

    for (genvar k = 0; k < NBANDS; k++) begin : g_pair
        band_slicer u_slice (
            .clk(clk), .rst_n(rst_n), .tick(period_tick),
            .ref_ext(ref_ext), .carrier(carrier[k]), .demand(demand[k])
        );
        gate_deadtime #(.DT_W(DT_W)) u_dead (
            .clk(clk), .rst_n(rst_n), .demand(demand[k]), .dead_len(dead_len),
            .side(side[k]), .up(gate_hi[k]), .lo(gate_lo[k])
        );
    end

    // Output level: count of pairs commanded high-side.
    always_comb begin
        level = '0;
        for (int k = 0; k < NBANDS; k++) level = level + LVL_W'(side[k]);
    end

    function automatic logic [NBANDS-1:0] thermo(input logic [LVL_W-1:0] n);
        logic [NBANDS-1:0] m;
        m = '0;
        for (int k = 0; k < NBANDS; k++) if (k < int'(n)) m[NBANDS-1-k] = 1'b1;
        return m;
    endfunction

    AST_LEVEL_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        side == thermo(level)) else $error("side pattern not thermometer"); // R4
endmodule

// File: tb/stacked_band_pwm_bench.sv
// Bench: behavioural cycle model compared every cycle plus directed scenarios.
module stacked_band_pwm_bench;
    localparam int CLK_NS = 10;
    localparam int PER    = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               period_tick = 1'b0;
    logic signed [15:0] ref_in = '0;
    logic [15:0]        amp1 = '0, amp2 = '0, amp3 = '0, amp4 = '0;
    logic [3:0]         dead_len = '0;
    logic [3:0]         gate_hi, gate_lo;
    logic [2:0]         level;

    stacked_band_pwm u_stacked_band_pwm (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .ref_in(ref_in),
        .amp1(amp1), .amp2(amp2), .amp3(amp3), .amp4(amp4), .dead_len(dead_len),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .level(level)
    );

    always #(CLK_NS/2) clk = ~clk;

    int nchk = 0, nfail = 0;
    int tcnt = 0;
    bit tick_en = 1'b0;

    // Tick source: one pulse every PER clocks.
    always @(posedge clk) begin
        #1;
        tcnt = (tcnt + 1) % PER;
        period_tick = tick_en && (tcnt == 0);
    end

    // Reference model state.
    int m_amp[4], m_armed[4], m_side[4], m_cnt[4];
    int m_ph = 0;

    function automatic int clampv(input int a);
        return (a > 8192) ? 8192 : a;
    endfunction

    always @(posedge clk) begin
        int dem[4];
        int base[4];
        if (!rst_n) begin
            for (int j = 0; j < 4; j++) begin
                m_amp[j] = 0; m_armed[j] = 0; m_side[j] = 0; m_cnt[j] = 0;
            end
            m_ph = 0;
        end else begin
            base[0] = m_amp[1]; base[1] = 0;
            base[2] = -m_amp[2]; base[3] = -(m_amp[2] + m_amp[3]);
            for (int j = 0; j < 4; j++) begin
                int car;
                car = base[j] + (m_amp[j] * m_ph) / PER;
                dem[j] = (m_armed[j] != 0 && int'(ref_in) > car) ? 1 : 0;
            end
            for (int j = 0; j < 4; j++) begin
                m_armed[j] = period_tick ? 1 : dem[j];
                if (dem[j] != m_side[j]) begin
                    m_side[j] = dem[j]; m_cnt[j] = int'(dead_len);
                end else if (m_cnt[j] > 0) m_cnt[j]--;
            end
            if (period_tick) begin
                m_amp[0] = clampv(int'(amp1)); m_amp[1] = clampv(int'(amp2));
                m_amp[2] = clampv(int'(amp3)); m_amp[3] = clampv(int'(amp4));
                m_ph = 0;
            end else if (m_ph < PER - 1) m_ph++;
        end
    end

    // Per-cycle comparison and duty counters.
    int hi_cnt[4], lo_cnt[4], rise0 = 0;
    logic prev_hi0 = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            int eh, el, lv;
            eh = 0; el = 0; lv = 0;
            for (int j = 0; j < 4; j++) begin
                if (m_side[j] != 0 && m_cnt[j] == 0) eh |= (1 << j);
                if (m_side[j] == 0 && m_cnt[j] == 0) el |= (1 << j);
                lv += m_side[j];
            end
            nchk++;
            if (int'(gate_hi) != eh || int'(gate_lo) != el || int'(level) != lv) begin
                nfail++;
                $display("FAIL R3/R4/R9 per-cycle: hi=%b lo=%b lvl=%0d expected hi=%b lo=%b lvl=%0d",
                         gate_hi, gate_lo, level, eh[3:0], el[3:0], lv);
            end
            for (int j = 0; j < 4; j++) begin
                hi_cnt[j] += gate_hi[j];
                lo_cnt[j] += gate_lo[j];
            end
            if (gate_hi[0] && !prev_hi0) rise0++;
        end
        prev_hi0 = gate_hi[0];
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic clr();
        for (int j = 0; j < 4; j++) begin hi_cnt[j] = 0; lo_cnt[j] = 0; end
        rise0 = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_duty(input string tag, input int e0, input int e1, input int e2, input int e3);
        chk(hi_cnt[0] == e0, {tag, " pair1"}, hi_cnt[0], e0);
        chk(hi_cnt[1] == e1, {tag, " pair2"}, hi_cnt[1], e1);
        chk(hi_cnt[2] == e2, {tag, " pair3"}, hi_cnt[2], e2);
        chk(hi_cnt[3] == e3, {tag, " pair4"}, hi_cnt[3], e3);
    endtask

    task automatic settle_and_measure();
        step(2 * PER);
        clr();
        step(PER);
    endtask

    task automatic wait_t(input int t);
        do step(1); while (tcnt != t);
    endtask

    initial begin
        step(3);
        // R10: reset state.
        chk(gate_hi == 4'h0, "R10 hi", int'(gate_hi), 0);
        chk(gate_lo == 4'hF, "R10 lo", int'(gate_lo), 15);
        chk(level == 3'd0, "R10 level", int'(level), 0);

        rst_n = 1'b1; tick_en = 1'b1;
        amp1 = 4096; amp2 = 4096; amp3 = 4096; amp4 = 4096;
        // R1/R3/R5: reference in the top band.
        ref_in = 6144;
        settle_and_measure();
        chk_duty("R1 R5 top band", 32, 64, 64, 64);
        chk(lo_cnt[0] == 32, "R3 pair1 low side", lo_cnt[0], 32);
        // R2: restart at period start.
        wait_t(2);
        chk(gate_hi[0] == 1'b1, "R2 on after restart", int'(gate_hi[0]), 1);
        wait_t(40);
        chk(gate_hi[0] == 1'b0, "R2 off late in period", int'(gate_hi[0]), 0);
        chk(level == 3'd3, "R4 level late in period", int'(level), 3);

        // R1/R5: other bands.
        ref_in = 2048;   settle_and_measure(); chk_duty("R1 R5 band2", 0, 32, 64, 64);
        ref_in = -2048;  settle_and_measure(); chk_duty("R1 R5 band3", 0, 0, 32, 64);
        ref_in = -6144;  settle_and_measure(); chk_duty("R1 R5 band4", 0, 0, 0, 32);
        ref_in = -9000;  settle_and_measure(); chk_duty("R4 below all", 0, 0, 0, 0);
        chk(level == 3'd0, "R4 level below all", int'(level), 0);

        // R6: zero-height top band stays flat at amp2.
        amp1 = 0; ref_in = 5000;
        settle_and_measure(); chk_duty("R6 zero band", 64, 64, 64, 64);
        chk(level == 3'd4, "R4 level above all", int'(level), 4);

        // R6: clamp to 8192 sets duty of the top band.
        amp1 = 20000; ref_in = 8192;
        settle_and_measure(); chk_duty("R6 clamp", 32, 64, 64, 64);

        // R7: toggling reference gives one turn-on per period.
        amp1 = 4096; ref_in = 6144;
        step(2 * PER);
        clr();
        for (int i = 0; i < PER; i++) begin
            ref_in = (i % 2 == 0) ? 16'sd5000 : 16'sd8000;
            step(1);
        end
        chk(rise0 == 1, "R7 turn-ons per period", rise0, 1);

        // R8: mid-period height change waits for the next tick.
        ref_in = 6144;
        step(2 * PER);
        wait_t(10);
        amp1 = 0;
        wait_t(50);
        chk(gate_hi[0] == 1'b0, "R8 old height kept", int'(gate_hi[0]), 0);
        step(PER);
        chk(gate_hi[0] == 1'b1, "R8 new height used", int'(gate_hi[0]), 1);

        // R9: blanking of three cycles on each change.
        amp1 = 4096; dead_len = 4'd3;
        settle_and_measure();
        chk(hi_cnt[0] == 29, "R9 hi with blanking", hi_cnt[0], 29);
        chk(lo_cnt[0] == 29, "R9 lo with blanking", lo_cnt[0], 29);
        chk(hi_cnt[1] == 64, "R9 steady pair untouched", hi_cnt[1], 64);

        step(4);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule